// File: doc/BRIEF.md
# Slow Chip-Select Bus Timing Sequencer

This block turns single host requests into strobe sequences for slow asynchronous devices on an external parallel bus, such as SRAM or NOR flash. A host hands over one read or write at a time with a ready/valid handshake. Each request carries a chip-select index, a 9-bit word address and 16-bit write data. The sequencer then drives the active-low chip selects, the output-enable and write-enable strobes, the address lines and the write-data bus with its drive enable. It finishes with a one-cycle done pulse, which on reads comes with the captured data.

Each of the six chip selects has its own timing word, loaded through a configuration write port. The word sets read and write wait lengths, write hold, bus-turnaround recovery, and extra first-access latency for reads and for writes. The block tracks which chip select and which page were used last. It adds the first-access latency only on the first access after reset, after a change of chip select, or after a change of page. It adds recovery only where a device that was just read could still be driving the bus.

Top module: `slowcs_seq`

## Requirements
- R1: After reset, all chip selects, OE and WE are high (inactive), the data drive enable is low, done is low, ready is high and every timing word reads as zero.
- R2: A configuration write stores cfg_word into the timing word of chip select cfg_cs. The word holds read wait in bits 3:0, write wait in bits 7:4, write hold in bits 11:8, recovery in bits 15:12, read delta in bits 23:16 and write delta in bits 31:24. Each chip select uses only its own word.
- R3: During the access phase, OE (on a read) or WE (on a write) is low for exactly wait+1 cycles. The addressed chip select, and only that one, is low, and the request address is on bus_addr. OE and WE are never low together.
- R4: After a write's WE rises, the chip select stays low with WE high and write data driven for write hold + 1 cycles.
- R5: If the previous accepted request was a read, and the new one goes to a different chip select or is a write, then all outputs stay inactive for max(recovery,1) cycles before the chip select asserts. The recovery value is taken from the chip select that was read. No other case inserts recovery.
- R6: On a first access the chip select is low with both strobes high for delta cycles (read delta or write delta) before the access phase. A first access is one after reset, one to a different chip select than the previous request, or one whose upper PAGE_BITS address bits differ from the previous request's. Other accesses get no delta phase.
- R7: rsp_done pulses for one cycle: the cycle after OE rises on a read, or the cycle after the hold phase on a write. On a read, rsp_rdata holds bus_din as sampled in the last OE-low cycle.
- R8: req_ready is high only while no transaction is in progress (from acceptance to the done cycle, exclusive). While it is low, no request is taken.
- R9: bus_dout_en is never high while OE is low. On writes it is high, with the request data on bus_dout, throughout the delta, access and hold phases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Timing word write strobe |
| cfg_cs | input | 3 | Chip select whose timing word is written |
| cfg_word | input | 32 | Timing word value |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request can be accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_cs | input | 3 | Target chip-select index |
| req_addr | input | 9 | Word address |
| req_wdata | input | 16 | Write data |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Read data, valid with rsp_done on reads |
| bus_cs_n | output | 6 | Active-low chip selects |
| bus_oe_n | output | 1 | Active-low output enable |
| bus_we_n | output | 1 | Active-low write enable |
| bus_addr | output | 9 | External address lines |
| bus_dout | output | 16 | Data driven onto the bus |
| bus_dout_en | output | 1 | Drive enable for bus_dout |
| bus_din | input | 16 | Data sampled from the bus |

## Verification
The assertions assume that req_cs is below six and that timing words are rewritten only while the sequencer is idle. A rewrite during a transaction would change its phase lengths partway through. The stimulus writes every timing word before any request is issued, and picks chip-select indices only from the six that exist. Requests are raised only in cycles where ready is high, and are dropped right after acceptance, so each transaction can be predicted from the requests that came before it.

// File: rtl/slowcs_pkg.sv
package slowcs_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_RECOV,
    PH_DELTA,
    PH_ACCESS,
    PH_HOLD
  } phase_t;

  // Field order sets the bit position of each field in the configuration word
  typedef struct packed {
    logic [7:0] wr_delta;
    logic [7:0] rd_delta;
    logic [3:0] recov;
    logic [3:0] wr_hold;
    logic [3:0] wr_wait;
    logic [3:0] rd_wait;
  } timing_t;

endpackage

// File: rtl/slowcs_cfg.sv
module slowcs_cfg
  import slowcs_pkg::*;
#(
  parameter int NCS = 6,
  parameter int CSW = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cfg_wr,
  input  logic [CSW-1:0] cfg_cs,
  input  logic [31:0]    cfg_word,
  input  logic [CSW-1:0] sel_cur,
  input  logic [CSW-1:0] sel_rec,
  output timing_t        tim_cur,
  output timing_t        tim_rec
);

  timing_t slots [NCS];

  always_ff @(posedge clk) begin
    for (int i = 0; i < NCS; i++) begin
      if (rst) begin
        slots[i] <= '0;
      end else if (cfg_wr && int'(cfg_cs) == i) begin
        slots[i] <= timing_t'(cfg_word);
      end
    end
  end

  always_comb begin
    tim_cur = '0;
    tim_rec = '0;
    if (int'(sel_cur) < NCS) tim_cur = slots[sel_cur];
    if (int'(sel_rec) < NCS) tim_rec = slots[sel_rec];
  end

endmodule

// File: rtl/slowcs_fsm.sv
module slowcs_fsm
  import slowcs_pkg::*;
#(
  parameter int NCS       = 6,
  parameter int CSW       = 3,
  parameter int AW        = 9,
  parameter int DW        = 16,
  parameter int PAGE_BITS = 5,
  parameter int CNTW      = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           req_valid,
  output logic           req_ready,
  input  logic           req_write,
  input  logic [CSW-1:0] req_cs,
  input  logic [AW-1:0]  req_addr,
  input  logic [DW-1:0]  req_wdata,
  output logic           rsp_done,
  output logic [DW-1:0]  rsp_rdata,
  output logic [CSW-1:0] sel_cur,
  output logic [CSW-1:0] sel_rec,
  input  timing_t        tim_cur,
  input  timing_t        tim_rec,
  output logic [NCS-1:0] bus_cs_n,
  output logic           bus_oe_n,
  output logic           bus_we_n,
  output logic [AW-1:0]  bus_addr,
  output logic [DW-1:0]  bus_dout,
  output logic           bus_dout_en,
  input  logic [DW-1:0]  bus_din
);

  localparam int PLO = AW - PAGE_BITS;

  phase_t                st_q, st_d;
  logic [CNTW-1:0]       cnt_q, cnt_d;
  logic                  wr_q, wr_d;
  logic [CSW-1:0]        cs_q, cs_d;
  logic [AW-1:0]         addr_q, addr_d;
  logic [DW-1:0]         wd_q, wd_d;
  logic [7:0]            dly_q, dly_d;
  logic                  last_rd_q;
  logic [CSW-1:0]        last_cs_q;
  logic                  pg_vld_q;
  logic [PAGE_BITS-1:0]  pg_q;
  logic                  accept, need_rec, first_acc, done_d, capture, active_d;
  logic [7:0]            dly_new;
  logic [3:0]            wait_len;

  assign req_ready = (st_q == PH_IDLE);
  assign accept    = req_valid && req_ready;
  assign sel_cur   = (st_q == PH_IDLE) ? req_cs : cs_q;
  assign sel_rec   = last_cs_q;

  assign need_rec  = last_rd_q && ((req_cs != last_cs_q) || req_write);
  assign first_acc = !pg_vld_q || (req_cs != last_cs_q) || (req_addr[AW-1:PLO] != pg_q);
  assign dly_new   = first_acc ? (req_write ? tim_cur.wr_delta : tim_cur.rd_delta) : 8'd0;
  assign wait_len  = ((st_q == PH_IDLE) ? req_write : wr_q) ? tim_cur.wr_wait : tim_cur.rd_wait;

  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q - 1'b1;
    wr_d    = wr_q;
    cs_d    = cs_q;
    addr_d  = addr_q;
    wd_d    = wd_q;
    dly_d   = dly_q;
    done_d  = 1'b0;
    capture = 1'b0;
    case (st_q)
      PH_IDLE: begin
        cnt_d = cnt_q;
        if (accept) begin
          wr_d   = req_write;
          cs_d   = req_cs;
          addr_d = req_addr;
          wd_d   = req_wdata;
          dly_d  = dly_new;
          if (need_rec) begin
            st_d  = PH_RECOV;
            cnt_d = (tim_rec.recov == 4'd0) ? '0 : CNTW'(tim_rec.recov - 4'd1);
          end else if (dly_new != 8'd0) begin
            st_d  = PH_DELTA;
            cnt_d = CNTW'(dly_new - 8'd1);
          end else begin
            st_d  = PH_ACCESS;
            cnt_d = CNTW'(wait_len);
          end
        end
      end
      PH_RECOV: begin
        if (cnt_q == '0) begin
          if (dly_q != 8'd0) begin
            st_d  = PH_DELTA;
            cnt_d = CNTW'(dly_q - 8'd1);
          end else begin
            st_d  = PH_ACCESS;
            cnt_d = CNTW'(wait_len);
          end
        end
      end
      PH_DELTA: begin
        if (cnt_q == '0) begin
          st_d  = PH_ACCESS;
          cnt_d = CNTW'(wait_len);
        end
      end
      PH_ACCESS: begin
        if (cnt_q == '0) begin
          if (wr_q) begin
            st_d  = PH_HOLD;
            cnt_d = CNTW'(tim_cur.wr_hold);
          end else begin
            st_d    = PH_IDLE;
            done_d  = 1'b1;
            capture = 1'b1;
          end
        end
      end
      PH_HOLD: begin
        if (cnt_q == '0) begin
          st_d   = PH_IDLE;
          done_d = 1'b1;
        end
      end
      default: st_d = PH_IDLE;
    endcase
  end

  assign active_d = (st_d == PH_DELTA) || (st_d == PH_ACCESS) || (st_d == PH_HOLD);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q        <= PH_IDLE;
      cnt_q       <= '0;
      wr_q        <= 1'b0;
      cs_q        <= '0;
      addr_q      <= '0;
      wd_q        <= '0;
      dly_q       <= '0;
      last_rd_q   <= 1'b0;
      last_cs_q   <= '0;
      pg_vld_q    <= 1'b0;
      pg_q        <= '0;
      rsp_done    <= 1'b0;
      rsp_rdata   <= '0;
      bus_cs_n    <= '1;
      bus_oe_n    <= 1'b1;
      bus_we_n    <= 1'b1;
      bus_addr    <= '0;
      bus_dout    <= '0;
      bus_dout_en <= 1'b0;
    end else begin
      st_q        <= st_d;
      cnt_q       <= cnt_d;
      wr_q        <= wr_d;
      cs_q        <= cs_d;
      addr_q      <= addr_d;
      wd_q        <= wd_d;
      dly_q       <= dly_d;
      rsp_done    <= done_d;
      if (capture) rsp_rdata <= bus_din;
      if (accept) begin
        last_rd_q <= !req_write;
        last_cs_q <= req_cs;
        pg_vld_q  <= 1'b1;
        pg_q      <= req_addr[AW-1:PLO];
      end
      bus_cs_n    <= active_d ? ~(NCS'(1) << cs_d) : '1;
      bus_oe_n    <= !((st_d == PH_ACCESS) && !wr_d);
      bus_we_n    <= !((st_d == PH_ACCESS) && wr_d);
      bus_addr    <= addr_d;
      bus_dout    <= wd_d;
      bus_dout_en <= active_d && wr_d;
    end
  end

  AST_OE_UNDRIVEN: assert property (@(posedge clk) disable iff (rst)
    !bus_oe_n |-> !bus_dout_en); // R9
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(!bus_oe_n && !bus_we_n)); // R3
  AST_ONE_CS: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~bus_cs_n)); // R3
  AST_STROBE_NEEDS_CS: assert property (@(posedge clk) disable iff (rst)
    (!bus_oe_n || !bus_we_n) |-> (bus_cs_n != '1)); // R3
  AST_READY_QUIET: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (bus_cs_n == '1 && bus_oe_n && bus_we_n && !bus_dout_en)); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    rsp_done |=> !rsp_done); // R7
  AST_WRITE_HOLD: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_we_n) |-> (bus_cs_n != '1 && bus_dout_en)); // R4

endmodule

// File: rtl/slowcs_seq.sv
module slowcs_seq
  import slowcs_pkg::*;
#(
  parameter int NCS       = 6,
  parameter int AW        = 9,
  parameter int DW        = 16,
  parameter int PAGE_BITS = 5,
  localparam int CSW      = $clog2(NCS)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cfg_wr,
  input  logic [CSW-1:0] cfg_cs,
  input  logic [31:0]    cfg_word,
  input  logic           req_valid,
  output logic           req_ready,
  input  logic           req_write,
  input  logic [CSW-1:0] req_cs,
  input  logic [AW-1:0]  req_addr,
  input  logic [DW-1:0]  req_wdata,
  output logic           rsp_done,
  output logic [DW-1:0]  rsp_rdata,
  output logic [NCS-1:0] bus_cs_n,
  output logic           bus_oe_n,
  output logic           bus_we_n,
  output logic [AW-1:0]  bus_addr,
  output logic [DW-1:0]  bus_dout,
  output logic           bus_dout_en,
  input  logic [DW-1:0]  bus_din
);

  logic [CSW-1:0] sel_cur, sel_rec;
  timing_t        tim_cur, tim_rec;

  slowcs_cfg #(.NCS(NCS), .CSW(CSW)) u_cfg (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_cs(cfg_cs), .cfg_word(cfg_word),
    .sel_cur(sel_cur), .sel_rec(sel_rec), .tim_cur(tim_cur), .tim_rec(tim_rec)
  );

  slowcs_fsm #(.NCS(NCS), .CSW(CSW), .AW(AW), .DW(DW), .PAGE_BITS(PAGE_BITS), .CNTW(8)) u_fsm (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_cs(req_cs), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
    .sel_cur(sel_cur), .sel_rec(sel_rec), .tim_cur(tim_cur), .tim_rec(tim_rec),
    .bus_cs_n(bus_cs_n), .bus_oe_n(bus_oe_n), .bus_we_n(bus_we_n),
    .bus_addr(bus_addr), .bus_dout(bus_dout), .bus_dout_en(bus_dout_en),
    .bus_din(bus_din)
  );

  AST_REQ_CS_RANGE: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |-> (int'(req_cs) < NCS)); // R2

endmodule

// File: tb/slowcs_seq_tb.sv
module slowcs_seq_tb;

  localparam int NCS = 6;
  localparam int AW  = 9;
  localparam int DW  = 16;
  localparam int PB  = 5;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_wr = 1'b0;
  logic [2:0]    cfg_cs = '0;
  logic [31:0]   cfg_word = '0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic          req_write = 1'b0;
  logic [2:0]    req_cs = '0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          rsp_done;
  logic [DW-1:0] rsp_rdata;
  logic [NCS-1:0] bus_cs_n;
  logic          bus_oe_n, bus_we_n, bus_dout_en;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_dout;
  logic [DW-1:0] bus_din;

  always #10 clk = ~clk;

  assign bus_din = {7'd0, bus_addr} ^ 16'h5A3C;

  slowcs_seq u_dut (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_cs(cfg_cs), .cfg_word(cfg_word),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_cs(req_cs), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
    .bus_cs_n(bus_cs_n), .bus_oe_n(bus_oe_n), .bus_we_n(bus_we_n),
    .bus_addr(bus_addr), .bus_dout(bus_dout), .bus_dout_en(bus_dout_en),
    .bus_din(bus_din)
  );

  typedef struct {
    logic [NCS-1:0] cs_n;
    logic           oe_n, we_n, den, done, ready, rd;
    logic [AW-1:0]  addr;
    logic [DW-1:0]  dout;
    string          tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_tests = 0;
  int   n_fail  = 0;
  bit   run     = 0;
  bit   finished = 0;

  int b_rdw[8], b_wrw[8], b_hold[8], b_rec[8], b_rdd[8], b_wrd[8];
  bit m_last_rd = 0;
  int m_last_cs = 0;
  bit m_pvld = 0;
  int m_page = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, expv, $time);
    end
  endtask

  function automatic exp_t idle_e(input string tag);
    exp_t e;
    e.cs_n = '1; e.oe_n = 1; e.we_n = 1; e.den = 0; e.done = 0; e.ready = 1; e.rd = 0;
    e.addr = '0; e.dout = '0; e.tag = tag;
    return e;
  endfunction

  always @(negedge clk) begin
    if (run) begin
      exp_t e;
      if (exp_q.size() > 0) e = exp_q.pop_front();
      else e = idle_e("R8");
      chk(bus_cs_n == e.cs_n, e.tag, "bus_cs_n", bus_cs_n, e.cs_n);
      chk(bus_oe_n == e.oe_n, e.tag, "bus_oe_n", bus_oe_n, e.oe_n);
      chk(bus_we_n == e.we_n, e.tag, "bus_we_n", bus_we_n, e.we_n);
      chk(bus_dout_en == e.den, e.tag, "bus_dout_en", bus_dout_en, e.den);
      chk(rsp_done == e.done, e.tag, "rsp_done", rsp_done, e.done);
      chk(req_ready == e.ready, e.tag, "req_ready R8", req_ready, e.ready);
      if (e.cs_n != '1) chk(bus_addr == e.addr, e.tag, "bus_addr", bus_addr, e.addr);
      if (e.den) chk(bus_dout == e.dout, e.tag, "bus_dout R9", bus_dout, e.dout);
      if (e.done && e.rd)
        chk(rsp_rdata == ({7'd0, e.addr} ^ 16'h5A3C), "R7", "rsp_rdata", rsp_rdata,
            {7'd0, e.addr} ^ 16'h5A3C);
    end
  end

  // R2: timing word layout {wr_delta, rd_delta, recov, wr_hold, wr_wait, rd_wait}
  task automatic set_cfg(input int cs, input int rdw, input int wrw, input int hold,
                         input int rec, input int rdd, input int wrd);
    @(negedge clk);
    cfg_wr = 1; cfg_cs = 3'(cs);
    cfg_word = {8'(wrd), 8'(rdd), 4'(rec), 4'(hold), 4'(wrw), 4'(rdw)};
    b_rdw[cs] = rdw; b_wrw[cs] = wrw; b_hold[cs] = hold;
    b_rec[cs] = rec; b_rdd[cs] = rdd; b_wrd[cs] = wrd;
    @(posedge clk);
    @(negedge clk);
    cfg_wr = 0;
  endtask

  function automatic int model_push(input bit wr, input int cs, input int addr, input int data);
    int   len = 0;
    bit   need_rec, first;
    int   nrec, dly, wlen;
    exp_t a;
    need_rec = m_last_rd && (cs != m_last_cs || wr);
    first = !m_pvld || cs != m_last_cs || (addr >> (AW - PB)) != m_page;
    nrec = need_rec ? ((b_rec[m_last_cs] == 0) ? 1 : b_rec[m_last_cs]) : 0;
    dly = first ? (wr ? b_wrd[cs] : b_rdd[cs]) : 0;
    wlen = (wr ? b_wrw[cs] : b_rdw[cs]) + 1;
    for (int i = 0; i < nrec; i++) begin
      a = idle_e("R5"); a.ready = 0; exp_q.push_back(a); len++;
    end
    a = idle_e("R6");
    a.ready = 0; a.cs_n = ~(NCS'(1) << cs); a.addr = AW'(addr);
    a.den = wr; a.dout = DW'(data);
    for (int i = 0; i < dly; i++) begin exp_q.push_back(a); len++; end
    a.tag = "R3";
    if (wr) a.we_n = 0; else a.oe_n = 0;
    for (int i = 0; i < wlen; i++) begin exp_q.push_back(a); len++; end
    if (wr) begin
      a.tag = "R4"; a.we_n = 1;
      for (int i = 0; i < b_hold[cs] + 1; i++) begin exp_q.push_back(a); len++; end
    end
    a = idle_e("R7"); a.done = 1; a.rd = !wr; a.addr = AW'(addr);
    exp_q.push_back(a); len++;
    m_last_rd = !wr; m_last_cs = cs; m_pvld = 1; m_page = addr >> (AW - PB);
    return len;
  endfunction

  task automatic do_req(input bit wr, input int cs, input int addr, input int data,
                        input int gap);
    int len;
    @(negedge clk);
    chk(req_ready == 1'b1, "R8", "ready before request", req_ready, 1);
    req_valid = 1; req_write = wr; req_cs = 3'(cs);
    req_addr = AW'(addr); req_wdata = DW'(data);
    @(posedge clk);
    len = model_push(wr, cs, addr, data);
    @(negedge clk);
    req_valid = 0;
    repeat (len - 1) @(posedge clk);
    repeat (gap) @(posedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) begin
      b_rdw[i] = 0; b_wrw[i] = 0; b_hold[i] = 0; b_rec[i] = 0; b_rdd[i] = 0; b_wrd[i] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk(bus_cs_n == '1, "R1", "bus_cs_n", bus_cs_n, 6'h3F);
    chk(bus_oe_n && bus_we_n, "R1", "strobes", {bus_oe_n, bus_we_n}, 2'b11);
    chk(!bus_dout_en, "R1", "bus_dout_en", bus_dout_en, 0);
    chk(!rsp_done, "R1", "rsp_done", rsp_done, 0);
    chk(req_ready, "R1", "req_ready", req_ready, 1);
    run = 1;
    // R2 distinct words per chip select; cs2 and cs4 keep the reset word of zero (R1)
    set_cfg(0, 2, 1, 2, 3, 4, 5);
    set_cfg(1, 0, 0, 0, 0, 0, 0);
    set_cfg(3, 0, 3, 0, 0, 2, 3);
    set_cfg(5, 15, 15, 15, 15, 10, 12);
    do_req(0, 0, 'h010, 0, 0);      // R6 first after reset: read delta 4
    do_req(0, 0, 'h012, 0, 1);      // same cs and page: no delta, no recovery
    do_req(1, 0, 'h013, 'hBEEF, 0); // R5 read then write same cs: 3 recovery
    do_req(1, 0, 'h014, 'h1234, 0); // write after write: none
    do_req(1, 0, 'h0F0, 'hA5A5, 2); // R6 page change: write delta 5
    do_req(0, 1, 'h000, 0, 0);      // cs change after write: delta 0, no recovery
    do_req(0, 3, 'h1FF, 0, 0);      // R5 recovery 0 yields 1; R6 delta 2
    do_req(1, 3, 'h1FF, 'h0F0F, 0); // R5 read then write same cs
    do_req(0, 5, 'h155, 0, 3);      // long waits, delta 10
    do_req(1, 5, 'h150, 'hC3C3, 0); // R4 hold 16 after recovery 15
    do_req(0, 2, 'h0AA, 0, 0);      // unconfigured cs uses zeros (R1)
    do_req(0, 2, 'h0AB, 0, 0);      // read after read same cs
    do_req(1, 4, 'h001, 'h7777, 0); // recovery uses cs2 value 0 -> 1
    repeat (4) @(posedge clk);
    @(negedge clk);
    run = 0;
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule